// File: doc/BRIEF.md
# Interprocessor doorbell and halt control register

This block is a 16-bit control and status word that a processor board shares with the other masters on a multiprocessor backplane. It holds five things. The first is a doorbell request that lets any master interrupt the local CPU. The second is the enable that gates that doorbell. The third is a switch that opens local memory to outside access. The fourth is a halt control that is active only on auxiliary boards. The fifth is a read-only copy of the DMA parity-error flag. The read word is assembled combinationally from the stored state and the parity input.

Writes arrive on a single strobe-qualified port. The `local_master` input tells the block whether the local CPU or an outside master owns the bus during a write. The `is_aux` input states whether the board is the arbiter or one of the auxiliaries. A write is taken on any cycle with `wr_en` high, so there is no back-pressure. Every pin is a plain level or a single-cycle pulse. The doorbell leaves the block as a level request with a fixed vector and priority level. The interrupt controller answers with a one-cycle grant.

Top module: `ipc_doorbell_reg`

## Requirements
- R1: `rd_data[15]` equals `dma_parity_err` in the same cycle, with no clock edge involved. Bits 14:9, bit 7 and bits 4:1 of `rd_data` are always zero, whatever has been written to them.
- R2: When `is_aux` is 1, a write with `wr_strobe[1]` set loads `wr_data[8]` into the halt bit at the next edge. `halt_req` and `rd_data[8]` show the halt bit.
- R3: When `is_aux` is 0, the halt bit is cleared at the next edge, and writes to bit 8 have no effect. As a result, `halt_req` and `rd_data[8]` read 0.
- R4: The doorbell-enable bit (bit 6) and the external-access bit (bit 5) load from a write with `wr_strobe[0]` set only when `local_master` is 1. A write from an outside master leaves both bits unchanged.
- R5: When `dc_ok` is 0 or `bus_init_wr` is 1, bits 6 and 5 are cleared at the next edge, and this wins over a write in the same cycle. An active-low `rst_n` clears every stored bit.
- R6: A write with `wr_strobe[0]` set and `wr_data[0]` = 1 sets the doorbell request only if bit 6 was already 1 before that write. Writing 0 to bit 0 has no effect.
- R7: `irq_grant` clears the doorbell request at the next edge. The request is held at 0 whenever bit 6 is 0, including in the cycle after bit 6 is cleared.
- R8: `irq_vector` is 0x204 and `irq_level` is 0x14 (the parameter defaults). `irq_req` shows the request state, which is also readable as `rd_data[0]`.
- R9: Byte lane 0 (`wr_strobe[0]`) covers bits 7:0 and byte lane 1 (`wr_strobe[1]`) covers bits 15:8. Bits in a lane whose strobe is 0 are not changed by the write.
- R10: If a doorbell set and a grant fall in the same cycle, the set wins and the request stays 1.
- R11: `mem_ext_en` shows bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-up reset |
| is_aux | input | 1 | 1 = auxiliary board, 0 = arbiter |
| local_master | input | 1 | 1 = local CPU owns the bus for this write |
| dc_ok | input | 1 | Supply good; 0 clears bits 6 and 5 |
| bus_init_wr | input | 1 | Pulse on a write to the bus-initialize register |
| wr_en | input | 1 | Write this cycle |
| wr_strobe | input | 2 | Byte-lane enables |
| wr_data | input | 16 | Write word |
| rd_data | output | 16 | Read word |
| dma_parity_err | input | 1 | Parity-error flag from the memory error register |
| irq_grant | input | 1 | Doorbell interrupt grant pulse |
| irq_req | output | 1 | Doorbell interrupt request |
| irq_vector | output | 10 | Doorbell vector |
| irq_level | output | 5 | Doorbell priority level |
| halt_req | output | 1 | Registered halt level to the CPU |
| mem_ext_en | output | 1 | External access to local memory allowed |

## Verification
The bench builds the block with its default parameters: a 10-bit vector of 0x204 and a 5-bit level of 0x14. Those defaults let the bench compare the interrupt identity against fixed constants. With the 16-bit word and two byte lanes, a single-lane write can be aimed at either the halt bit or the low control bits in isolation. The same geometry also makes it possible to write every always-zero position while leaving the live bits untouched.

// File: rtl/ipc_pkg.sv
package ipc_pkg;
  localparam int REG_W   = 16;
  localparam int LANE_W  = 8;
  localparam int LANES   = REG_W / LANE_W;
  localparam int POS_PERR = 15;
  localparam int POS_HALT = 8;
  localparam int POS_IE   = 6;
  localparam int POS_EAE  = 5;
  localparam int POS_RQ   = 0;
  localparam int LANE_HALT = POS_HALT / LANE_W;
  localparam int LANE_CTL  = POS_IE / LANE_W;
endpackage

// File: rtl/ipc_enable_bits.sv
module ipc_enable_bits (
  input  logic clk,
  input  logic rst_n,
  input  logic dc_ok,
  input  logic bus_init_wr,
  input  logic local_master,
  input  logic wr_en,
  input  logic lane_en,
  input  logic wr_ie,
  input  logic wr_eae,
  output logic ie_d,
  output logic ie_q,
  output logic eae_q
);
  logic clr, load, eae_d;

  assign clr  = !dc_ok || bus_init_wr;
  assign load = wr_en && lane_en && local_master;

  always_comb begin
    ie_d  = ie_q;
    eae_d = eae_q;
    if (clr) begin
      ie_d  = 1'b0;
      eae_d = 1'b0;
    end else if (load) begin
      ie_d  = wr_ie;
      eae_d = wr_eae;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q  <= 1'b0;
      eae_q <= 1'b0;
    end else begin
      ie_q  <= ie_d;
      eae_q <= eae_d;
    end
  end

  assert_bus_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!dc_ok || bus_init_wr) |=> (!ie_q && !eae_q));
  assert_ext_write_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !local_master && dc_ok && !bus_init_wr) |=> ($stable(ie_q) && $stable(eae_q)));
endmodule

// File: rtl/ipc_halt_ctl.sv
module ipc_halt_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic is_aux,
  input  logic wr_en,
  input  logic lane_en,
  input  logic wr_bit,
  output logic halt_q
);
  logic halt_d;

  always_comb begin
    halt_d = halt_q;
    if (!is_aux)
      halt_d = 1'b0;
    else if (wr_en && lane_en)
      halt_d = wr_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) halt_q <= 1'b0;
    else        halt_q <= halt_d;
  end

  assert_arbiter_no_halt_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !is_aux |=> !halt_q);
endmodule

// File: rtl/ipc_doorbell.sv
module ipc_doorbell (
  input  logic clk,
  input  logic rst_n,
  input  logic ie_q,
  input  logic ie_d,
  input  logic set_wr,
  input  logic grant,
  output logic req_q
);
  logic set_ok, req_d;

  assign set_ok = set_wr && ie_q;

  always_comb begin
    req_d = req_q;
    if (set_ok)     req_d = 1'b1;
    else if (grant) req_d = 1'b0;
    if (!ie_d)      req_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_d;
  end

  assert_held_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ie_q |-> !req_q);
  assert_grant_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && grant && !set_wr) |=> !req_q);
  assert_no_spurious_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_q && !set_wr) |=> !req_q);
endmodule

// File: rtl/ipc_doorbell_reg.sv
module ipc_doorbell_reg
  import ipc_pkg::*;
#(
  parameter int VEC_W = 10,
  parameter logic [VEC_W-1:0] IRQ_VECTOR = 10'h204,
  parameter int LVL_W = 5,
  parameter logic [LVL_W-1:0] IRQ_LEVEL = 5'h14
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 is_aux,
  input  logic                 local_master,
  input  logic                 dc_ok,
  input  logic                 bus_init_wr,
  input  logic                 wr_en,
  input  logic [LANES-1:0]     wr_strobe,
  input  logic [REG_W-1:0]     wr_data,
  output logic [REG_W-1:0]     rd_data,
  input  logic                 dma_parity_err,
  input  logic                 irq_grant,
  output logic                 irq_req,
  output logic [VEC_W-1:0]     irq_vector,
  output logic [LVL_W-1:0]     irq_level,
  output logic                 halt_req,
  output logic                 mem_ext_en
);
  logic ie_d, ie_q, eae_q, halt_q, req_q, set_wr;

  assign set_wr = wr_en && wr_strobe[POS_RQ / LANE_W] && wr_data[POS_RQ];

  ipc_enable_bits u_enable (
    .clk(clk), .rst_n(rst_n), .dc_ok(dc_ok), .bus_init_wr(bus_init_wr),
    .local_master(local_master), .wr_en(wr_en), .lane_en(wr_strobe[LANE_CTL]),
    .wr_ie(wr_data[POS_IE]), .wr_eae(wr_data[POS_EAE]),
    .ie_d(ie_d), .ie_q(ie_q), .eae_q(eae_q)
  );

  ipc_halt_ctl u_halt (
    .clk(clk), .rst_n(rst_n), .is_aux(is_aux), .wr_en(wr_en),
    .lane_en(wr_strobe[LANE_HALT]), .wr_bit(wr_data[POS_HALT]), .halt_q(halt_q)
  );

  ipc_doorbell u_bell (
    .clk(clk), .rst_n(rst_n), .ie_q(ie_q), .ie_d(ie_d), .set_wr(set_wr),
    .grant(irq_grant), .req_q(req_q)
  );

  always_comb begin
    rd_data           = '0;
    rd_data[POS_PERR] = dma_parity_err;
    rd_data[POS_HALT] = halt_q;
    rd_data[POS_IE]   = ie_q;
    rd_data[POS_EAE]  = eae_q;
    rd_data[POS_RQ]   = req_q;
  end

  assign irq_req    = req_q;
  assign irq_vector = IRQ_VECTOR;
  assign irq_level  = IRQ_LEVEL;
  assign halt_req   = halt_q;
  assign mem_ext_en = eae_q;

  assert_req_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> rd_data[POS_IE]);
endmodule

// File: tb/ipc_doorbell_reg_bench.sv
module ipc_doorbell_reg_bench;
  logic clk = 1'b0;
  logic rst_n, is_aux, local_master, dc_ok, bus_init_wr, wr_en;
  logic [1:0] wr_strobe;
  logic [15:0] wr_data, rd_data;
  logic dma_parity_err, irq_grant, irq_req, halt_req, mem_ext_en;
  logic [9:0] irq_vector;
  logic [4:0] irq_level;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ipc_doorbell_reg u_ipc_doorbell_reg (
    .clk(clk), .rst_n(rst_n), .is_aux(is_aux), .local_master(local_master),
    .dc_ok(dc_ok), .bus_init_wr(bus_init_wr), .wr_en(wr_en), .wr_strobe(wr_strobe),
    .wr_data(wr_data), .rd_data(rd_data), .dma_parity_err(dma_parity_err),
    .irq_grant(irq_grant), .irq_req(irq_req), .irq_vector(irq_vector),
    .irq_level(irq_level), .halt_req(halt_req), .mem_ext_en(mem_ext_en)
  );

  // {aux, lm, we, stb[1:0], data[15:0], gnt, dcok, binit, exp_rd[15:0], exp_irq}
  localparam int N = 17;
  localparam logic [40:0] TBL [0:N-1] = '{
    {1'b1,1'b1,1'b1,2'b11,16'h0160,1'b0,1'b1,1'b0,16'h0160,1'b0}, // R2 R4
    {1'b1,1'b1,1'b1,2'b01,16'h0061,1'b0,1'b1,1'b0,16'h0161,1'b1}, // R6 R9
    {1'b1,1'b1,1'b0,2'b00,16'h0000,1'b1,1'b1,1'b0,16'h0160,1'b0}, // R7 grant
    {1'b1,1'b0,1'b1,2'b11,16'h0001,1'b0,1'b1,1'b0,16'h0061,1'b1}, // R4 R2 external
    {1'b1,1'b0,1'b1,2'b01,16'h0001,1'b1,1'b1,1'b0,16'h0061,1'b1}, // R10
    {1'b1,1'b1,1'b1,2'b01,16'h0000,1'b0,1'b1,1'b0,16'h0000,1'b0}, // R7 held clear
    {1'b1,1'b1,1'b1,2'b01,16'h0021,1'b0,1'b1,1'b0,16'h0020,1'b0}, // R6 disabled
    {1'b1,1'b1,1'b1,2'b01,16'h0041,1'b0,1'b1,1'b0,16'h0040,1'b0}, // R6 prior enable
    {1'b0,1'b1,1'b1,2'b11,16'h0161,1'b0,1'b1,1'b0,16'h0061,1'b1}, // R3
    {1'b0,1'b1,1'b1,2'b01,16'h0060,1'b0,1'b1,1'b1,16'h0000,1'b0}, // R5 bus init
    {1'b1,1'b1,1'b1,2'b01,16'h0060,1'b0,1'b1,1'b0,16'h0060,1'b0}, // R4
    {1'b1,1'b1,1'b0,2'b00,16'h0000,1'b0,1'b0,1'b0,16'h0000,1'b0}, // R5 dc_ok low
    {1'b1,1'b1,1'b1,2'b01,16'h0060,1'b0,1'b0,1'b0,16'h0000,1'b0}, // R5 over write
    {1'b1,1'b1,1'b1,2'b10,16'h0060,1'b0,1'b1,1'b0,16'h0000,1'b0}, // R9 lane 0 off
    {1'b1,1'b1,1'b1,2'b10,16'h0100,1'b0,1'b1,1'b0,16'h0100,1'b0}, // R2 R9
    {1'b0,1'b1,1'b0,2'b00,16'h0000,1'b0,1'b1,1'b0,16'h0000,1'b0}, // R3 halt drops
    {1'b1,1'b1,1'b1,2'b11,16'h7E9E,1'b0,1'b1,1'b0,16'h0000,1'b0}  // R1 zero bits
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    wr_en = 1'b0; wr_strobe = 2'b00; wr_data = 16'h0; irq_grant = 1'b0;
    bus_init_wr = 1'b0; dc_ok = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0; is_aux = 1'b1; local_master = 1'b1; dma_parity_err = 1'b0;
    idle();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk("R5 reset rd_data", rd_data, 16'h0);
    chk("R8 reset irq_req", irq_req, 1'b0);
    chk("R2 reset halt_req", halt_req, 1'b0);
    chk("R11 reset mem_ext_en", mem_ext_en, 1'b0);
    chk("R8 vector", irq_vector, 10'h204);
    chk("R8 level", irq_level, 5'h14);

    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      {is_aux, local_master, wr_en, wr_strobe, wr_data, irq_grant, dc_ok, bus_init_wr} = TBL[i][40:17];
      @(posedge clk); #1;
      chk($sformatf("row %0d rd_data", i), rd_data, TBL[i][16:1]);
      chk($sformatf("row %0d R8 irq_req", i), irq_req, TBL[i][0]);
      chk($sformatf("row %0d R2 halt_req", i), halt_req, TBL[i][9]);
      chk($sformatf("row %0d R11 mem_ext_en", i), mem_ext_en, TBL[i][6]);
    end

    @(negedge clk); idle(); is_aux = 1'b1;
    dma_parity_err = 1'b1; #1;
    chk("R1 parity bit combinational", rd_data, 16'h8000);
    dma_parity_err = 1'b0; #1;
    chk("R1 parity bit follows low", rd_data, 16'h0000);

    @(negedge clk); local_master = 1'b1; wr_en = 1'b1; wr_strobe = 2'b11; wr_data = 16'h0160;
    @(negedge clk); wr_data = 16'h0061; wr_strobe = 2'b01;
    @(negedge clk); idle(); #1;
    chk("R6 setup before reset", rd_data, 16'h0161);
    rst_n = 1'b0; #1;
    chk("R5 async reset clears all", rd_data, 16'h0000);
    chk("R2 reset clears halt", halt_req, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule